// File: doc/BRIEF.md
# Pipeline Stage Control Carrier

This block is the set of four inter-stage registers of a five-stage in-order processor pipeline: fetch-to-decode, decode-to-execute, execute-to-memory and memory-to-writeback. It moves the decoded control bits, the destination register number and the data words that travel with them from one stage to the next. Nothing is stored after the writeback stage.

Control bits are grouped by the stage that consumes them. The execute group (operand source, ALU operation, destination-field select) is held only in the decode-to-execute register. The memory group (load, store, branch-taken) is carried one stage further, and the writeback group (register write, take-load-data) goes all the way to writeback. The destination register number is chosen in decode from one of two instruction fields and travels with the writeback group.

Every register loads on every clock edge; there is no write enable. A bubble request turns the slot entering execute into a no-op by zeroing all three control groups written into the decode-to-execute register, while the data words pass unchanged. A synchronous active-low reset clears every control group and every carried value. Instruction decoding, the ALU, the register file and the memories are outside this block.

Top module: `pipe_ctrl_chain`

## Requirements
- R1: While rst_n is low at a rising clock edge, every control output at the execute, memory and writeback stages reads 0 after that edge.
- R2: if_instr and if_pc_next presented before a rising edge appear on id_instr and id_pc_next after that edge.
- R3: The destination number sent towards execute is id_instr[15:11] when id_dst_sel is 1 and id_instr[20:16] when id_dst_sel is 0; it appears on ex_dst one edge later, on mem_dst two edges later and on wb_dst three edges later.
- R4: The execute group (id_alu_src, id_alu_op, id_dst_sel) presented in decode appears on ex_alu_src, ex_alu_op, ex_dst_sel one edge later.
- R5: The memory group (id_mem_rd, id_mem_wr, id_br_take) appears on mem_rd, mem_wr, mem_br_take two edges later, and id_reg_wr appears on mem_reg_wr two edges later.
- R6: The writeback group (id_reg_wr, id_mem_to_reg) appears on wb_reg_wr, wb_mem_to_reg three edges later.
- R7: When bubble_req is 1 at an edge, the execute group seen one edge later, the memory group seen two edges later and the writeback group seen three edges later are all 0; the data words of that slot (ex_rs_val, ex_rt_val, ex_imm) are still carried.
- R8: id_rs_val, id_rt_val and id_imm appear at execute one edge later; ex_alu_result appears on mem_alu_result one edge later, and the execute-stage rt value appears on mem_store_data one edge later; mem_load_data and mem_alu_result appear on wb_load_data and wb_alu_result one edge later.
- R9: Every register loads on every edge: slots presented back to back each appear in consecutive cycles, with no slot held or skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| if_instr | input | 32 | Fetched instruction word |
| if_pc_next | input | 32 | Incremented fetch address |
| id_instr | output | 32 | Instruction word held for decode |
| id_pc_next | output | 32 | Incremented address held for decode |
| id_alu_src | input | 1 | Decoded: ALU second operand is the immediate |
| id_alu_op | input | 2 | Decoded: ALU operation class |
| id_dst_sel | input | 1 | Decoded: 1 picks bits [15:11], 0 picks bits [20:16] as destination |
| id_mem_rd | input | 1 | Decoded: data memory read |
| id_mem_wr | input | 1 | Decoded: data memory write |
| id_br_take | input | 1 | Decoded: branch target selection |
| id_reg_wr | input | 1 | Decoded: register file write |
| id_mem_to_reg | input | 1 | Decoded: write back load data instead of ALU result |
| id_rs_val | input | 32 | First register operand |
| id_rt_val | input | 32 | Second register operand |
| id_imm | input | 32 | Sign-extended immediate |
| bubble_req | input | 1 | Insert a no-op into the execute stage |
| ex_alu_src | output | 1 | Execute group: operand source |
| ex_alu_op | output | 2 | Execute group: ALU operation class |
| ex_dst_sel | output | 1 | Execute group: destination field select |
| ex_dst | output | 5 | Destination number at execute |
| ex_rs_val | output | 32 | First operand at execute |
| ex_rt_val | output | 32 | Second operand at execute |
| ex_imm | output | 32 | Immediate at execute |
| ex_alu_result | input | 32 | ALU result produced in execute |
| mem_rd | output | 1 | Memory group: read |
| mem_wr | output | 1 | Memory group: write |
| mem_br_take | output | 1 | Memory group: branch selection |
| mem_reg_wr | output | 1 | Register write bit at memory stage |
| mem_dst | output | 5 | Destination number at memory stage |
| mem_alu_result | output | 32 | ALU result at memory stage |
| mem_store_data | output | 32 | Store data at memory stage |
| mem_load_data | input | 32 | Data read from memory |
| wb_reg_wr | output | 1 | Writeback group: register write |
| wb_mem_to_reg | output | 1 | Writeback group: take load data |
| wb_dst | output | 5 | Destination number at writeback |
| wb_alu_result | output | 32 | ALU result at writeback |
| wb_load_data | output | 32 | Load data at writeback |

## Verification
A wrong bit in a control group shows at the port of the stage that uses it, one edge after decode for the execute group, two for the memory group and three for the writeback group. A bubble that fails to clear a group shows as a stray write, load or branch bit exactly at that group's stage, while a group held or skipped breaks the one-slot-per-cycle order of a back-to-back stream. A wrong destination pick or a destination that slips against its write bit shows on ex_dst first and then on mem_dst and wb_dst, always beside the register-write bit of the same slot.

// File: rtl/pipe_ctrl_pkg.sv
// Shared widths and control group types for the pipeline control carrier.
// Assumes a fixed 32-bit instruction word with two 5-bit register fields.
package pipe_ctrl_pkg;

    parameter int DATA_W  = 32;
    parameter int INSTR_W = 32;
    parameter int REG_W   = 5;
    parameter int ALUOP_W = 2;
    parameter int RT_LSB  = 16;
    parameter int RD_LSB  = 11;

    // Group used and dropped in the execute stage.
    typedef struct packed {
        logic               alu_src;
        logic [ALUOP_W-1:0] alu_op;
        logic               dst_sel;
    } ex_grp_t;

    // Group used in the memory stage.
    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic br_take;
    } mem_grp_t;

    // Group used in the writeback stage.
    typedef struct packed {
        logic reg_wr;
        logic mem_to_reg;
    } wb_grp_t;

endpackage

// File: rtl/if_id_stage.sv
// Fetch-to-decode register: captures the fetched word and the incremented
// address on every edge. Assumes no stall path holds this register.
module if_id_stage #(
    parameter int IW = pipe_ctrl_pkg::INSTR_W,
    parameter int AW = pipe_ctrl_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] instr_in,
    input  logic [AW-1:0] pc_next_in,
    output logic [IW-1:0] instr_q,
    output logic [AW-1:0] pc_next_q
);

    // Load fetch results every cycle, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            instr_q   <= '0;
            pc_next_q <= '0;
        end else begin
            instr_q   <= instr_in;
            pc_next_q <= pc_next_in;
        end
    end

    a_r2_fetch_carried: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (instr_q == $past(instr_in)) && (pc_next_q == $past(pc_next_in)));

endmodule

// File: rtl/id_ex_stage.sv
// Decode-to-execute register. Picks the destination number from one of the
// two instruction fields, holds all three control groups and the operands.
// A bubble request zeroes every control group written here; operands pass.
module id_ex_stage
    import pipe_ctrl_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int RW = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bubble,
    input  logic [RW-1:0] rt_fld,
    input  logic [RW-1:0] rd_fld,
    input  ex_grp_t       ex_in,
    input  mem_grp_t      mem_in,
    input  wb_grp_t       wb_in,
    input  logic [DW-1:0] rs_in,
    input  logic [DW-1:0] rt_in,
    input  logic [DW-1:0] imm_in,
    output ex_grp_t       ex_q,
    output mem_grp_t      mem_q,
    output wb_grp_t       wb_q,
    output logic [RW-1:0] dst_q,
    output logic [DW-1:0] rs_q,
    output logic [DW-1:0] rt_q,
    output logic [DW-1:0] imm_q
);

    logic [RW-1:0] dst_pick;
    ex_grp_t       ex_nxt;
    mem_grp_t      mem_nxt;
    wb_grp_t       wb_nxt;
    logic          rst_low_q;

    // Destination choice made in decode from the raw select bit.
    always_comb begin
        dst_pick = ex_in.dst_sel ? rd_fld : rt_fld;
    end

    // Bubble gating of all control groups entering execute.
    always_comb begin
        if (bubble) begin
            ex_nxt  = '0;
            mem_nxt = '0;
            wb_nxt  = '0;
        end else begin
            ex_nxt  = ex_in;
            mem_nxt = mem_in;
            wb_nxt  = wb_in;
        end
    end

    // Capture the decode slot every cycle, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_q  <= '0;
            mem_q <= '0;
            wb_q  <= '0;
            dst_q <= '0;
            rs_q  <= '0;
            rt_q  <= '0;
            imm_q <= '0;
        end else begin
            ex_q  <= ex_nxt;
            mem_q <= mem_nxt;
            wb_q  <= wb_nxt;
            dst_q <= dst_pick;
            rs_q  <= rs_in;
            rt_q  <= rt_in;
            imm_q <= imm_in;
        end
    end

    // Remember whether the last edge saw reset, for the reset check.
    always_ff @(posedge clk) begin
        rst_low_q <= !rst_n;
    end

    // Check that a reset edge left every group clear.
    always @(negedge clk) begin
        if (rst_low_q) begin
            a_r1_reset_clears: assert ((ex_q == '0) && (mem_q == '0) && (wb_q == '0));
        end
    end

    a_r7_bubble_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> (ex_q == '0) && (mem_q == '0) && (wb_q == '0));

    a_r3_dst_pick: assert property (@(posedge clk) disable iff (!rst_n)
        ex_in.dst_sel |=> dst_q == $past(rd_fld));

    a_r3_dst_pick_rt: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_in.dst_sel |=> dst_q == $past(rt_fld));

endmodule

// File: rtl/ex_mem_stage.sv
// Execute-to-memory register. Drops the execute group; carries the memory
// and writeback groups, the destination, the ALU result and store data.
module ex_mem_stage
    import pipe_ctrl_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int RW = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mem_grp_t      mem_in,
    input  wb_grp_t       wb_in,
    input  logic [RW-1:0] dst_in,
    input  logic [DW-1:0] alu_in,
    input  logic [DW-1:0] store_in,
    output mem_grp_t      mem_q,
    output wb_grp_t       wb_q,
    output logic [RW-1:0] dst_q,
    output logic [DW-1:0] alu_q,
    output logic [DW-1:0] store_q
);

    // Capture the execute slot every cycle, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q   <= '0;
            wb_q    <= '0;
            dst_q   <= '0;
            alu_q   <= '0;
            store_q <= '0;
        end else begin
            mem_q   <= mem_in;
            wb_q    <= wb_in;
            dst_q   <= dst_in;
            alu_q   <= alu_in;
            store_q <= store_in;
        end
    end

    a_r5_mem_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (mem_q == $past(mem_in)) && (wb_q.reg_wr == $past(wb_in.reg_wr)));

endmodule

// File: rtl/mem_wb_stage.sv
// Memory-to-writeback register, the last of the chain. Carries only the
// writeback group, the destination and the two candidate write values.
module mem_wb_stage
    import pipe_ctrl_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int RW = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  wb_grp_t       wb_in,
    input  logic [RW-1:0] dst_in,
    input  logic [DW-1:0] alu_in,
    input  logic [DW-1:0] load_in,
    output wb_grp_t       wb_q,
    output logic [RW-1:0] dst_q,
    output logic [DW-1:0] alu_q,
    output logic [DW-1:0] load_q
);

    // Capture the memory slot every cycle, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_q   <= '0;
            dst_q  <= '0;
            alu_q  <= '0;
            load_q <= '0;
        end else begin
            wb_q   <= wb_in;
            dst_q  <= dst_in;
            alu_q  <= alu_in;
            load_q <= load_in;
        end
    end

    a_r6_wb_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (wb_q == $past(wb_in)) && (dst_q == $past(dst_in)));

endmodule

// File: rtl/pipe_ctrl_chain.sv
// Top of the pipeline control carrier: four inter-stage registers in a row.
// Assumes decoding, ALU, register file and memories sit outside and feed
// the stage inputs combinationally within each cycle.
module pipe_ctrl_chain
    import pipe_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] if_instr,
    input  logic [DATA_W-1:0]  if_pc_next,
    output logic [INSTR_W-1:0] id_instr,
    output logic [DATA_W-1:0]  id_pc_next,
    input  logic               id_alu_src,
    input  logic [ALUOP_W-1:0] id_alu_op,
    input  logic               id_dst_sel,
    input  logic               id_mem_rd,
    input  logic               id_mem_wr,
    input  logic               id_br_take,
    input  logic               id_reg_wr,
    input  logic               id_mem_to_reg,
    input  logic [DATA_W-1:0]  id_rs_val,
    input  logic [DATA_W-1:0]  id_rt_val,
    input  logic [DATA_W-1:0]  id_imm,
    input  logic               bubble_req,
    output logic               ex_alu_src,
    output logic [ALUOP_W-1:0] ex_alu_op,
    output logic               ex_dst_sel,
    output logic [REG_W-1:0]   ex_dst,
    output logic [DATA_W-1:0]  ex_rs_val,
    output logic [DATA_W-1:0]  ex_rt_val,
    output logic [DATA_W-1:0]  ex_imm,
    input  logic [DATA_W-1:0]  ex_alu_result,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic               mem_br_take,
    output logic               mem_reg_wr,
    output logic [REG_W-1:0]   mem_dst,
    output logic [DATA_W-1:0]  mem_alu_result,
    output logic [DATA_W-1:0]  mem_store_data,
    input  logic [DATA_W-1:0]  mem_load_data,
    output logic               wb_reg_wr,
    output logic               wb_mem_to_reg,
    output logic [REG_W-1:0]   wb_dst,
    output logic [DATA_W-1:0]  wb_alu_result,
    output logic [DATA_W-1:0]  wb_load_data
);

    ex_grp_t  dec_ex;
    mem_grp_t dec_mem;
    wb_grp_t  dec_wb;
    ex_grp_t  ex_ex;
    mem_grp_t ex_mem;
    wb_grp_t  ex_wb;
    mem_grp_t mm_mem;
    wb_grp_t  mm_wb;
    wb_grp_t  wb_wb;

    // Group the decoded control bits by the stage that consumes them.
    always_comb begin
        dec_ex.alu_src     = id_alu_src;
        dec_ex.alu_op      = id_alu_op;
        dec_ex.dst_sel     = id_dst_sel;
        dec_mem.mem_rd     = id_mem_rd;
        dec_mem.mem_wr     = id_mem_wr;
        dec_mem.br_take    = id_br_take;
        dec_wb.reg_wr      = id_reg_wr;
        dec_wb.mem_to_reg  = id_mem_to_reg;
    end

    if_id_stage u_if_id (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_in   (if_instr),
        .pc_next_in (if_pc_next),
        .instr_q    (id_instr),
        .pc_next_q  (id_pc_next)
    );

    id_ex_stage u_id_ex (
        .clk    (clk),
        .rst_n  (rst_n),
        .bubble (bubble_req),
        .rt_fld (id_instr[RT_LSB +: REG_W]),
        .rd_fld (id_instr[RD_LSB +: REG_W]),
        .ex_in  (dec_ex),
        .mem_in (dec_mem),
        .wb_in  (dec_wb),
        .rs_in  (id_rs_val),
        .rt_in  (id_rt_val),
        .imm_in (id_imm),
        .ex_q   (ex_ex),
        .mem_q  (ex_mem),
        .wb_q   (ex_wb),
        .dst_q  (ex_dst),
        .rs_q   (ex_rs_val),
        .rt_q   (ex_rt_val),
        .imm_q  (ex_imm)
    );

    ex_mem_stage u_ex_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .mem_in   (ex_mem),
        .wb_in    (ex_wb),
        .dst_in   (ex_dst),
        .alu_in   (ex_alu_result),
        .store_in (ex_rt_val),
        .mem_q    (mm_mem),
        .wb_q     (mm_wb),
        .dst_q    (mem_dst),
        .alu_q    (mem_alu_result),
        .store_q  (mem_store_data)
    );

    mem_wb_stage u_mem_wb (
        .clk     (clk),
        .rst_n   (rst_n),
        .wb_in   (mm_wb),
        .dst_in  (mem_dst),
        .alu_in  (mem_alu_result),
        .load_in (mem_load_data),
        .wb_q    (wb_wb),
        .dst_q   (wb_dst),
        .alu_q   (wb_alu_result),
        .load_q  (wb_load_data)
    );

    // Present each stage's group on its own ports.
    always_comb begin
        ex_alu_src    = ex_ex.alu_src;
        ex_alu_op     = ex_ex.alu_op;
        ex_dst_sel    = ex_ex.dst_sel;
        mem_rd        = mm_mem.mem_rd;
        mem_wr        = mm_mem.mem_wr;
        mem_br_take   = mm_mem.br_take;
        mem_reg_wr    = mm_wb.reg_wr;
        wb_reg_wr     = wb_wb.reg_wr;
        wb_mem_to_reg = wb_wb.mem_to_reg;
    end

    a_r4_ex_group: assert property (@(posedge clk) disable iff (!rst_n)
        !bubble_req |=> (ex_alu_src == $past(id_alu_src)) && (ex_alu_op == $past(id_alu_op))
                        && (ex_dst_sel == $past(id_dst_sel)));

endmodule

// File: tb/test_pipe_ctrl_chain.sv
`timescale 1ns/1ps
module test_pipe_ctrl_chain;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] if_instr = '0, if_pc_next = '0;
    logic [31:0] id_instr, id_pc_next;
    logic        id_alu_src = 0, id_dst_sel = 0, id_mem_rd = 0, id_mem_wr = 0;
    logic        id_br_take = 0, id_reg_wr = 0, id_mem_to_reg = 0;
    logic [1:0]  id_alu_op = '0;
    logic [31:0] id_rs_val = '0, id_rt_val = '0, id_imm = '0;
    logic        bubble_req = 1'b0;
    logic        ex_alu_src, ex_dst_sel;
    logic [1:0]  ex_alu_op;
    logic [4:0]  ex_dst, mem_dst, wb_dst;
    logic [31:0] ex_rs_val, ex_rt_val, ex_imm;
    logic [31:0] ex_alu_result = '0, mem_load_data = '0;
    logic        mem_rd, mem_wr, mem_br_take, mem_reg_wr;
    logic [31:0] mem_alu_result, mem_store_data;
    logic        wb_reg_wr, wb_mem_to_reg;
    logic [31:0] wb_alu_result, wb_load_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pipe_ctrl_chain i_pipe_ctrl_chain (
        .clk(clk), .rst_n(rst_n), .if_instr(if_instr), .if_pc_next(if_pc_next),
        .id_instr(id_instr), .id_pc_next(id_pc_next),
        .id_alu_src(id_alu_src), .id_alu_op(id_alu_op), .id_dst_sel(id_dst_sel),
        .id_mem_rd(id_mem_rd), .id_mem_wr(id_mem_wr), .id_br_take(id_br_take),
        .id_reg_wr(id_reg_wr), .id_mem_to_reg(id_mem_to_reg),
        .id_rs_val(id_rs_val), .id_rt_val(id_rt_val), .id_imm(id_imm),
        .bubble_req(bubble_req),
        .ex_alu_src(ex_alu_src), .ex_alu_op(ex_alu_op), .ex_dst_sel(ex_dst_sel),
        .ex_dst(ex_dst), .ex_rs_val(ex_rs_val), .ex_rt_val(ex_rt_val), .ex_imm(ex_imm),
        .ex_alu_result(ex_alu_result),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_br_take(mem_br_take),
        .mem_reg_wr(mem_reg_wr), .mem_dst(mem_dst),
        .mem_alu_result(mem_alu_result), .mem_store_data(mem_store_data),
        .mem_load_data(mem_load_data),
        .wb_reg_wr(wb_reg_wr), .wb_mem_to_reg(wb_mem_to_reg), .wb_dst(wb_dst),
        .wb_alu_result(wb_alu_result), .wb_load_data(wb_load_data)
    );

    // Control vector: [8]reg_wr [7]mem_to_reg [6]mem_rd [5]mem_wr [4]br_take
    //                 [3]alu_src [2:1]alu_op [0]dst_sel
    task automatic set_ctrl(input logic [8:0] c);
        {id_reg_wr, id_mem_to_reg, id_mem_rd, id_mem_wr, id_br_take,
         id_alu_src, id_alu_op, id_dst_sel} = c;
    endtask

    function automatic logic [31:0] ex_obs();
        return {28'd0, ex_alu_src, ex_alu_op, ex_dst_sel};
    endfunction
    function automatic logic [31:0] mem_obs();
        return {28'd0, mem_reg_wr, mem_rd, mem_wr, mem_br_take};
    endfunction
    function automatic logic [31:0] wb_obs();
        return {30'd0, wb_reg_wr, wb_mem_to_reg};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R1: reset clears every control group even with all decoded bits high.
    task automatic t_reset();
        rst_n = 1'b0;
        set_ctrl(9'h1FF);
        repeat (3) @(negedge clk);
        chk("R1 ex group at reset", ex_obs(), 32'h0);
        chk("R1 mem group at reset", mem_obs(), 32'h0);
        chk("R1 wb group at reset", wb_obs(), 32'h0);
        set_ctrl(9'h0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R2 and R9: fetch words cross into decode one edge later, every cycle.
    task automatic t_fetch();
        logic [31:0] w[3] = '{32'hA5A5_0001, 32'h1234_5678, 32'hFFFF_0000};
        for (int k = 0; k < 3; k++) begin
            if_instr   = w[k];
            if_pc_next = 32'h0000_1000 + 32'(4 * k);
            @(negedge clk);
            chk("R2 id_instr", id_instr, w[k]);
            chk("R9 id_pc_next each cycle", id_pc_next, 32'h0000_1000 + 32'(4 * k));
        end
    endtask

    // R3-R6, R9: back-to-back slots with distinct groups and destinations.
    task automatic t_stream();
        logic [8:0]  cv[4];
        logic [31:0] w;
        logic [4:0]  rt_f, rd_f;
        rt_f = 5'd9;
        rd_f = 5'd22;
        w = (32'(rt_f) << 16) | (32'(rd_f) << 11);
        cv[0] = 9'b1_1_1_0_0_1_00_0;
        cv[1] = 9'b1_0_0_0_0_0_10_1;
        cv[2] = 9'b0_0_0_1_0_1_00_0;
        cv[3] = 9'b0_0_0_0_1_0_01_1;
        if_instr = w;
        @(negedge clk);
        for (int j = 0; j < 7; j++) begin
            if (j >= 1) begin
                chk("R4 ex group", ex_obs(), {28'd0, cv[j-1][3:0]});
                chk("R3 ex_dst pick", {27'd0, ex_dst}, {27'd0, cv[j-1][0] ? rd_f : rt_f});
            end
            if (j >= 2 && j <= 5) begin
                chk("R5 mem group", mem_obs(), {28'd0, cv[j-2][8], cv[j-2][6:4]});
                chk("R3 mem_dst", {27'd0, mem_dst}, {27'd0, cv[j-2][0] ? rd_f : rt_f});
            end
            if (j >= 3) begin
                chk("R6 wb group", wb_obs(), {30'd0, cv[j-3][8:7]});
                chk("R3 wb_dst", {27'd0, wb_dst}, {27'd0, cv[j-3][0] ? rd_f : rt_f});
            end
            if (j < 4) set_ctrl(cv[j]);
            else       set_ctrl(9'h0);
            if (j >= 4) break;
            @(negedge clk);
        end
        for (int j = 5; j < 7; j++) begin
            @(negedge clk);
            chk("R6 wb group tail", wb_obs(), {30'd0, cv[j-3][8:7]});
        end
    endtask

    // R8: data words travel beside the control groups.
    task automatic t_data();
        id_rs_val = 32'h1111_2222;
        id_rt_val = 32'h3333_4444;
        id_imm    = 32'hFFFF_FFFC;
        ex_alu_result = 32'hDEAD_BEEF;
        mem_load_data = 32'h0BAD_F00D;
        @(negedge clk);
        chk("R8 ex_rs_val", ex_rs_val, 32'h1111_2222);
        chk("R8 ex_rt_val", ex_rt_val, 32'h3333_4444);
        chk("R8 ex_imm", ex_imm, 32'hFFFF_FFFC);
        chk("R8 mem_alu_result", mem_alu_result, 32'hDEAD_BEEF);
        chk("R8 wb_load_data", wb_load_data, 32'h0BAD_F00D);
        id_rt_val = 32'h5555_6666;
        ex_alu_result = 32'h0;
        mem_load_data = 32'h0;
        @(negedge clk);
        chk("R8 mem_store_data", mem_store_data, 32'h3333_4444);
        chk("R8 wb_alu_result", wb_alu_result, 32'hDEAD_BEEF);
    endtask

    // R7: a bubble slot is empty at every stage while its data still flows.
    task automatic t_bubble();
        set_ctrl(9'h1FF);
        bubble_req = 1'b1;
        id_rs_val = 32'hCAFE_0007;
        @(negedge clk);
        chk("R7 ex group zero in bubble", ex_obs(), 32'h0);
        chk("R7 data carried in bubble", ex_rs_val, 32'hCAFE_0007);
        bubble_req = 1'b0;
        @(negedge clk);
        chk("R7 ex group after bubble", ex_obs(), 32'hF);
        chk("R7 mem group zero in bubble", mem_obs(), 32'h0);
        @(negedge clk);
        chk("R7 mem group after bubble", mem_obs(), 32'hF);
        chk("R7 wb group zero in bubble", wb_obs(), 32'h0);
        set_ctrl(9'h0);
        @(negedge clk);
        chk("R7 wb group after bubble", wb_obs(), 32'h3);
    endtask

    initial begin
        t_reset();
        t_fetch();
        t_stream();
        t_data();
        t_bubble();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule